// File: doc/BRIEF.md
# Sequential Buffer RAM Access Port

This block lets an 8-bit host bus move bytes into and out of a 2K x 8 buffer RAM through three registers. The RAM is split into eight 256-byte pages. The host sets an 11-bit pointer by writing a pointer high register and then a pointer low register. It then reads or writes the data register as many times as it needs.

The pointer high register also holds two mode bits. One sets the direction of the data accesses that follow. The other decides whether the pointer steps forward after each data access. In read direction the block prefetches: the byte at the pointer is already in the data register when the host reads it, and each read fetches the next byte. After a transfer the host can read the pointer back to learn how many bytes were moved.

The RAM is expected to have an asynchronous read: read data follows the RAM address within the same cycle.

Top module: `ram_ptr_port`

## Requirements
- R1: After reset the pointer is 0x000, the direction is write, auto-increment is off and the data register holds 0x00. Reads at offsets 2, 3 and 4 all return 0x00.
- R2: A write to offset 2 loads the direction from bit 7 (1 = read, 0 = write), auto-increment from bit 6 (1 = on) and pointer bits 10:8 from bits 2:0. Reading offset 2 returns those bits in the same positions, and bits 5:3 read as 0.
- R3: A write to offset 3 loads pointer bits 7:0. Reading offset 3 returns pointer bits 7:0.
- R4: When the direction is read, a write to offset 3 fetches the RAM byte at the new pointer into the data register. The byte is readable in the next cycle.
- R5: In read direction, a read of offset 4 returns the prefetched byte. The pointer then advances if auto-increment is on, and the byte at the resulting pointer is fetched, ready in the next cycle.
- R6: In write direction, a write to offset 4 stores the byte at the current pointer in the same cycle. The pointer then advances if auto-increment is on.
- R7: With auto-increment off, data accesses leave the pointer unchanged. Repeated reads return the same byte, and repeated writes overwrite the same location.
- R8: The pointer wraps from 0x7FF to 0x000, and it crosses page boundaries without stopping.
- R9: A data access that does not match the set direction is ignored. A data write in read direction stores nothing and leaves the pointer alone. A data read in write direction leaves the pointer alone.
- R10: The RAM write enable is high only in a cycle with a data register write in write direction.
- R11: Offsets 0, 1, 5, 6 and 7 read as 0x00, and writes to them change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | 3 | Host register offset |
| rd_i | input | 1 | Host read strobe, one cycle per access |
| wr_i | input | 1 | Host write strobe, one cycle per access |
| wdata_i | input | 8 | Host write data |
| rdata_o | output | 8 | Host read data for the register at addr_i |
| ram_addr_o | output | 11 | RAM address |
| ram_wdata_o | output | 8 | RAM write data |
| ram_we_o | output | 1 | RAM write enable |
| ram_re_o | output | 1 | RAM fetch into the data register this cycle |
| ram_rdata_i | input | 8 | RAM asynchronous read data |

## Verification
The assertions take two things for granted. First, the host never raises its read and write strobes in the same cycle. Second, the RAM read data is valid in the same cycle as the address. The bench meets the first because every host access is a task that drives exactly one strobe for a single cycle. It meets the second with a bench RAM array whose read data follows the address through a continuous assignment. Direction-mismatched and unused-offset accesses are also driven through the same single-strobe tasks, so they keep within those assumptions.

// File: rtl/ram_ptr_pkg.sv
package ram_ptr_pkg;
  localparam int unsigned REG_AW  = 3;
  localparam int unsigned DIR_BIT = 7;
  localparam int unsigned INC_BIT = 6;

  typedef enum logic [REG_AW-1:0] {
    OFS_PTR_HI = 3'd2,
    OFS_PTR_LO = 3'd3,
    OFS_DATA   = 3'd4
  } reg_ofs_e;

  typedef struct packed {
    logic ld_hi;
    logic ld_lo;
    logic data_rd;
    logic data_wr;
  } host_op_t;
endpackage

// File: rtl/ptr_decode.sv
module ptr_decode
  import ram_ptr_pkg::*;
(
  input  logic [REG_AW-1:0] addr_i,
  input  logic              rd_i,
  input  logic              wr_i,
  output host_op_t          op_o
);
  always_comb begin
    op_o.ld_hi   = wr_i && (addr_i == OFS_PTR_HI);
    op_o.ld_lo   = wr_i && (addr_i == OFS_PTR_LO);
    op_o.data_wr = wr_i && (addr_i == OFS_DATA);
    op_o.data_rd = rd_i && !wr_i && (addr_i == OFS_DATA);
  end
endmodule

// File: rtl/ptr_counter.sv
module ptr_counter
  import ram_ptr_pkg::*;
#(
  parameter int unsigned ADDR_W = 11,
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  host_op_t          op_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic              dir_rd_o,
  output logic              inc_o,
  output logic [ADDR_W-1:0] ptr_o,
  output logic [ADDR_W-1:0] ptr_nxt_o
);
  localparam int unsigned PAGE_W = ADDR_W - DATA_W;

  logic              dir_q, inc_q;
  logic [ADDR_W-1:0] ptr_q, ptr_d;
  logic              adv;

  // step only when the access matches the set direction
  assign adv = inc_q && ((op_i.data_rd && dir_q) || (op_i.data_wr && !dir_q));

  always_comb begin
    ptr_d = ptr_q;
    if (op_i.ld_lo)      ptr_d = {ptr_q[ADDR_W-1:DATA_W], wdata_i};
    else if (op_i.ld_hi) ptr_d = {wdata_i[PAGE_W-1:0], ptr_q[DATA_W-1:0]};
    else if (adv)        ptr_d = ptr_q + ADDR_W'(1);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ptr_q <= '0;
      dir_q <= 1'b0;
      inc_q <= 1'b0;
    end else begin
      ptr_q <= ptr_d;
      if (op_i.ld_hi) begin
        dir_q <= wdata_i[DIR_BIT];
        inc_q <= wdata_i[INC_BIT];
      end
    end
  end

  assign dir_rd_o  = dir_q;
  assign inc_o     = inc_q;
  assign ptr_o     = ptr_q;
  assign ptr_nxt_o = ptr_d;
endmodule

// File: rtl/ptr_data_reg.sv
module ptr_data_reg #(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              fetch_i,
  input  logic [DATA_W-1:0] ram_rdata_i,
  output logic [DATA_W-1:0] data_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      data_o <= '0;
    else if (fetch_i) data_o <= ram_rdata_i;
  end
endmodule

// File: rtl/ram_ptr_port.sv
module ram_ptr_port
  import ram_ptr_pkg::*;
#(
  parameter int unsigned ADDR_W = 11,
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [2:0]        addr_i,
  input  logic              rd_i,
  input  logic              wr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic [ADDR_W-1:0] ram_addr_o,
  output logic [DATA_W-1:0] ram_wdata_o,
  output logic              ram_we_o,
  output logic              ram_re_o,
  input  logic [DATA_W-1:0] ram_rdata_i
);
  host_op_t          op;
  logic              dir_q, inc_q, fetch;
  logic [ADDR_W-1:0] ptr_q, ptr_nxt;
  logic [DATA_W-1:0] data_q, hi_rb;

  ptr_decode u_dec (
    .addr_i (addr_i),
    .rd_i   (rd_i),
    .wr_i   (wr_i),
    .op_o   (op)
  );

  ptr_counter #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_cnt (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .op_i      (op),
    .wdata_i   (wdata_i),
    .dir_rd_o  (dir_q),
    .inc_o     (inc_q),
    .ptr_o     (ptr_q),
    .ptr_nxt_o (ptr_nxt)
  );

  // prefetch on pointer-low load or data read, read direction only
  assign fetch = dir_q && (op.ld_lo || op.data_rd);

  ptr_data_reg #(.DATA_W(DATA_W)) u_dat (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .fetch_i     (fetch),
    .ram_rdata_i (ram_rdata_i),
    .data_o      (data_q)
  );

  assign ram_addr_o  = fetch ? ptr_nxt : ptr_q;
  assign ram_wdata_o = wdata_i;
  assign ram_we_o    = op.data_wr && !dir_q;
  assign ram_re_o    = fetch;

  always_comb begin
    hi_rb          = DATA_W'(ptr_q[ADDR_W-1:DATA_W]);
    hi_rb[DIR_BIT] = dir_q;
    hi_rb[INC_BIT] = inc_q;
  end

  always_comb begin
    case (addr_i)
      OFS_PTR_HI: rdata_o = hi_rb;
      OFS_PTR_LO: rdata_o = ptr_q[DATA_W-1:0];
      OFS_DATA:   rdata_o = data_q;
      default:    rdata_o = '0;
    endcase
  end
endmodule

// File: rtl/ram_ptr_port_chk.sv
module ram_ptr_port_chk
  import ram_ptr_pkg::*;
#(
  parameter int unsigned ADDR_W = 11,
  parameter int unsigned DATA_W = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [2:0]        addr_i,
  input logic              rd_i,
  input logic              wr_i,
  input logic [DATA_W-1:0] wdata_i,
  input logic              ram_we_o,
  input logic              ram_re_o,
  input logic [DATA_W-1:0] ram_rdata_i,
  input logic [ADDR_W-1:0] ptr_q,
  input logic              dir_q,
  input logic              inc_q,
  input logic [DATA_W-1:0] data_q
);
  logic dwr, drd;
  assign dwr = wr_i && (addr_i == OFS_DATA);
  assign drd = rd_i && !wr_i && (addr_i == OFS_DATA);

  a_r10_we_only_data_wr: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ram_we_o |-> (dwr && !dir_q));

  a_r3_lo_load: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && addr_i == OFS_PTR_LO) |=> (ptr_q[DATA_W-1:0] == $past(wdata_i)));

  a_r4_fetch_capture: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ram_re_o |=> (data_q == $past(ram_rdata_i)));

  a_r5_read_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (drd && dir_q && inc_q) |=> (ptr_q == $past(ptr_q) + ADDR_W'(1)));

  a_r6_write_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dwr && !dir_q && inc_q) |=> (ptr_q == $past(ptr_q) + ADDR_W'(1)));

  a_r7_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((dwr || drd) && !inc_q) |=> $stable(ptr_q));

  a_r9_wr_in_rd_dir: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dwr && dir_q) |-> !ram_we_o);

  a_r9_ptr_kept: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((dwr && dir_q) || (drd && !dir_q)) |=> $stable(ptr_q));
endmodule

bind ram_ptr_port ram_ptr_port_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .addr_i      (addr_i),
  .rd_i        (rd_i),
  .wr_i        (wr_i),
  .wdata_i     (wdata_i),
  .ram_we_o    (ram_we_o),
  .ram_re_o    (ram_re_o),
  .ram_rdata_i (ram_rdata_i),
  .ptr_q       (ptr_q),
  .dir_q       (dir_q),
  .inc_q       (inc_q),
  .data_q      (data_q)
);

// File: tb/tb_ram_ptr_port.sv
module tb_ram_ptr_port;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [2:0]  addr = '0;
  logic        rd = 1'b0, wr = 1'b0;
  logic [7:0]  wdata = '0;
  logic [7:0]  rdata;
  logic [10:0] ram_addr;
  logic [7:0]  ram_wdata, ram_rdata;
  logic        ram_we, ram_re;
  logic [7:0]  mem [2048];
  logic [7:0]  ref_mem [2048];
  logic        last_we;
  int checks = 0, fails = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  ram_ptr_port dut (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .rd_i(rd), .wr_i(wr),
    .wdata_i(wdata), .rdata_o(rdata), .ram_addr_o(ram_addr),
    .ram_wdata_o(ram_wdata), .ram_we_o(ram_we), .ram_re_o(ram_re),
    .ram_rdata_i(ram_rdata)
  );

  assign ram_rdata = mem[ram_addr];
  always @(posedge clk) if (ram_we) mem[ram_addr] <= ram_wdata;

  task automatic chk(string req, logic [10:0] act, logic [10:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic host_wr(logic [2:0] a, logic [7:0] d);
    @(negedge clk);
    addr = a; wdata = d; wr = 1'b1;
    #1 last_we = ram_we;
    @(negedge clk);
    wr = 1'b0; addr = '0;
  endtask

  task automatic host_rd(logic [2:0] a, output logic [7:0] d);
    @(negedge clk);
    addr = a; rd = 1'b1;
    #1 d = rdata;
    @(negedge clk);
    rd = 1'b0; addr = '0;
  endtask

  task automatic peek(logic [2:0] a, output logic [7:0] d);
    @(negedge clk);
    addr = a;
    #1 d = rdata;
  endtask

  task automatic t_reset();
    logic [7:0] d;
    peek(3'd2, d); chk("R1 hi", 11'(d), 11'h0);
    peek(3'd3, d); chk("R1 lo", 11'(d), 11'h0);
    peek(3'd4, d); chk("R1 data", 11'(d), 11'h0);
  endtask

  task automatic t_ptr_load();
    logic [7:0] d;
    host_wr(3'd2, 8'h45); peek(3'd2, d); chk("R2 hi", 11'(d), 11'h45);
    host_wr(3'd2, 8'hFF); peek(3'd2, d); chk("R2 hi bits5:3 zero", 11'(d), 11'hC7);
    host_wr(3'd3, 8'h3C); peek(3'd3, d); chk("R3 lo", 11'(d), 11'h3C);
  endtask

  task automatic t_seq_write();
    logic [7:0] d;
    host_wr(3'd2, 8'h41); host_wr(3'd3, 8'hFC);
    for (int i = 0; i < 6; i++) begin
      host_wr(3'd4, 8'h50 + 8'(i));
      chk("R10 we on data write", 11'(last_we), 11'h1);
      ref_mem[11'h1FC + 11'(i)] = 8'h50 + 8'(i);
    end
    for (int i = 0; i < 6; i++)
      chk("R6 stored", 11'(mem[11'h1FC + 11'(i)]), 11'(ref_mem[11'h1FC + 11'(i)]));
    peek(3'd2, d); chk("R8 page cross hi", 11'(d), 11'h42);
    peek(3'd3, d); chk("R6 count lo", 11'(d), 11'h02);
  endtask

  task automatic t_seq_read();
    logic [7:0] d;
    host_wr(3'd2, 8'hC1); host_wr(3'd3, 8'hF0);
    peek(3'd4, d); chk("R4 prefetch", 11'(d), 11'(ref_mem[11'h1F0]));
    for (int i = 0; i < 5; i++) begin
      host_rd(3'd4, d);
      chk("R5 seq read", 11'(d), 11'(ref_mem[11'h1F0 + 11'(i)]));
    end
    peek(3'd3, d); chk("R5 count lo", 11'(d), 11'hF5);
  endtask

  task automatic t_no_inc();
    logic [7:0] d;
    host_wr(3'd2, 8'h83); host_wr(3'd3, 8'h10);
    for (int i = 0; i < 3; i++) begin
      host_rd(3'd4, d); chk("R7 same byte", 11'(d), 11'(ref_mem[11'h310]));
    end
    peek(3'd3, d); chk("R7 ptr held rd", 11'(d), 11'h10);
    host_wr(3'd2, 8'h03); host_wr(3'd3, 8'h20);
    host_wr(3'd4, 8'h11); host_wr(3'd4, 8'h22);
    ref_mem[11'h320] = 8'h22;
    chk("R7 overwrite", 11'(mem[11'h320]), 11'h22);
    chk("R7 next untouched", 11'(mem[11'h321]), 11'(ref_mem[11'h321]));
    peek(3'd3, d); chk("R7 ptr held wr", 11'(d), 11'h20);
  endtask

  task automatic t_wrap();
    logic [7:0] d;
    host_wr(3'd2, 8'h47); host_wr(3'd3, 8'hFF); host_wr(3'd4, 8'hA5);
    ref_mem[11'h7FF] = 8'hA5;
    chk("R8 top byte", 11'(mem[11'h7FF]), 11'hA5);
    peek(3'd2, d); chk("R8 wrap hi", 11'(d), 11'h40);
    peek(3'd3, d); chk("R8 wrap lo", 11'(d), 11'h00);
    host_wr(3'd2, 8'hC7); host_wr(3'd3, 8'hFE);
    host_rd(3'd4, d); chk("R8 rd 7FE", 11'(d), 11'(ref_mem[11'h7FE]));
    host_rd(3'd4, d); chk("R8 rd 7FF", 11'(d), 11'hA5);
    host_rd(3'd4, d); chk("R8 rd 000", 11'(d), 11'(ref_mem[11'h000]));
  endtask

  task automatic t_ignored();
    logic [7:0] d;
    host_wr(3'd2, 8'hC2); host_wr(3'd3, 8'h00);
    host_wr(3'd4, 8'h99);
    chk("R9 no we in rd dir", 11'(last_we), 11'h0);
    chk("R9 ram kept", 11'(mem[11'h200]), 11'(ref_mem[11'h200]));
    peek(3'd3, d); chk("R9 ptr kept wr", 11'(d), 11'h00);
    host_wr(3'd2, 8'h42); host_wr(3'd3, 8'h08);
    host_rd(3'd4, d);
    peek(3'd3, d); chk("R9 ptr kept rd", 11'(d), 11'h08);
  endtask

  task automatic t_unused();
    logic [7:0] d;
    host_wr(3'd2, 8'h45); host_wr(3'd3, 8'h67);
    for (int a = 0; a < 8; a++) begin
      if (a >= 2 && a <= 4) continue;
      host_wr(3'(a), 8'hFF);
      peek(3'(a), d); chk("R11 reads zero", 11'(d), 11'h0);
    end
    peek(3'd2, d); chk("R11 hi kept", 11'(d), 11'h45);
    peek(3'd3, d); chk("R11 lo kept", 11'(d), 11'h67);
  endtask

  initial begin
    for (int i = 0; i < 2048; i++) begin
      mem[i] = 8'(i * 7 + 3) ^ 8'(i >> 8);
      ref_mem[i] = mem[i];
    end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_ptr_load();
    t_seq_write();
    t_seq_read();
    t_no_inc();
    t_wrap();
    t_ignored();
    t_unused();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog act=timeout exp=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule